// File: doc/BRIEF.md
# Configuration Space Address Router

The router sits between a flat, memory-mapped configuration window and the configuration registers of a single bus level. Every incoming request carries an address, a byte count and, for writes, data. After the address is masked with a window mask, it is split into a 5-bit device number, a 3-bit function number and an 8-bit register offset. Together these name one of 256 device/function slots. The offset and the byte count are then forwarded unchanged to whichever function agent has claimed that slot.

Function agents announce themselves through a static claim list, one entry per agent: a valid bit and an 8-bit slot number. Reads to a slot that nobody claims are answered by the router itself with all-ones data trimmed to the access width. Writes to such a slot are dropped and recorded as an error. Requests with an illegal byte count are recorded as a different error. Two agents that claim the same slot are a wiring mistake, and that is recorded as a third error.

Every accepted request produces exactly one response two cycles later. A new request may be issued on every cycle.

Top module: `cfg_router`

## Requirements
- R1: The slot number is bits 15:8 of the masked address. Device is bits 15:11, function is bits 10:8, and `claim_slot` entries hold {device, function} in that bit order. Bits 7:0 are the register offset.
- R2: A legal request to a claimed slot raises exactly one bit of `fn_sel`, the one for the claiming agent, for one cycle, in the cycle after `req_valid`. In that same cycle `fn_offset`, `fn_size`, `fn_write` and `fn_wdata` equal the request's values.
- R3: A forwarded read returns the selected agent's `fn_rdata` word on `rsp_rdata` with `rsp_valid` one cycle after the select, which is two cycles after the request. A forwarded write responds in that same cycle with zero data.
- R4: A read of an unclaimed slot selects no agent. It responds two cycles after the request with 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF for size 4.
- R5: A legal-size write to an unclaimed slot selects no agent, responds with zero data, and sets `err_status[1]`.
- R6: `req_size` is a byte count, and only 1, 2 and 4 are legal. Any other value selects no agent, responds with zero data, and sets only `err_status[0]`.
- R7: While two valid claim entries hold the same slot, `err_status[2]` is set one cycle later. Requests to that slot go to the lowest-numbered claiming agent.
- R8: The bits of `err_status` are sticky: once set, they stay set until reset. Reset clears them and holds `fn_sel` and `rsp_valid` low.
- R9: Requests may be issued on consecutive cycles, and each one gets its own select and response in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Window address before masking |
| req_size | input | 3 | Access byte count |
| req_wdata | input | 32 | Write data |
| claim_valid | input | NUM_FN | Claim entry valid per agent |
| claim_slot | input | NUM_FN*8 | Claimed {device, function} per agent |
| fn_sel | output | NUM_FN | One-hot agent select |
| fn_write | output | 1 | Forwarded direction |
| fn_offset | output | 8 | Forwarded register offset |
| fn_size | output | 3 | Forwarded byte count |
| fn_wdata | output | 32 | Forwarded write data |
| fn_rdata | input | NUM_FN*32 | Read data from each agent |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Response read data |
| err_status | output | 3 | Sticky errors: [0] size, [1] unclaimed write, [2] duplicate claim |

## Verification
The assertions run on every cycle. They check that the agent select is never more than one-hot, that a select only follows a request, and that an illegal byte count or an unclaimed slot never produces a select. They also check that every select is followed by a response, that a duplicate claim reaches the status register, and that error bits never clear on their own. Several properties only the bench scenarios can show. These include whether the right agent was chosen, and whether the offset, size and data reached it intact. They also include the exact all-ones width returned for each access size, the lowest-index choice between duplicate claimants, and that order is kept across back-to-back traffic.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int OFF_W  = 8;
  localparam int SLOT_W = DEV_W + FN_W;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 3;
  localparam int ERR_W  = 3;

  localparam int ERR_SIZE   = 0;
  localparam int ERR_ABS_WR = 1;
  localparam int ERR_DUP    = 2;

  typedef enum logic [1:0] {
    KIND_FWD_RD    = 2'd0,
    KIND_FWD_WR    = 2'd1,
    KIND_ABSENT_RD = 2'd2,
    KIND_NODATA    = 2'd3
  } rsp_kind_e;

  function automatic logic size_is_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [DATA_W-1:0] sized_ones(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] v;
    case (sz)
      3'd1:    v = 32'h0000_00FF;
      3'd2:    v = 32'h0000_FFFF;
      3'd4:    v = 32'hFFFF_FFFF;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [SLOT_W-1:0] slot,
  output logic [OFF_W-1:0]  offset,
  output logic              legal
);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = addr & WIN_MASK;
    slot   = masked[OFF_W+SLOT_W-1:OFF_W];
    offset = masked[OFF_W-1:0];
    legal  = size_is_legal(size);
  end

endmodule

// File: rtl/cfgr_match.sv
module cfgr_match
  import cfgr_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input  logic [NUM_FN-1:0]        claim_valid,
  input  logic [NUM_FN*SLOT_W-1:0] claim_slot,
  input  logic [SLOT_W-1:0]        tgt_slot,
  output logic [NUM_FN-1:0]        hit_vec,
  output logic                     hit,
  output logic                     dup
);

  logic [NUM_FN-1:0] raw_hit;

  // per-agent comparators
  for (genvar g = 0; g < NUM_FN; g++) begin : g_cmp
    assign raw_hit[g] = claim_valid[g] &&
                        (claim_slot[g*SLOT_W +: SLOT_W] == tgt_slot);
  end

  // lowest index wins when several agents match
  always_comb begin
    hit_vec = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (raw_hit[i] && !hit) begin
        hit_vec[i] = 1'b1;
        hit        = 1'b1;
      end
    end
  end

  // pairwise occupancy clash detection over the whole claim list
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NUM_FN; i++) begin
      for (int j = i + 1; j < NUM_FN; j++) begin
        if (claim_valid[i] && claim_valid[j] &&
            (claim_slot[i*SLOT_W +: SLOT_W] == claim_slot[j*SLOT_W +: SLOT_W]))
          dup = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgr_resp.sv
module cfgr_resp
  import cfgr_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  rsp_kind_e                s1_kind,
  input  logic [SIZE_W-1:0]        s1_size,
  input  logic [NUM_FN-1:0]        sel,
  input  logic [NUM_FN*DATA_W-1:0] fn_rdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata
);

  logic [DATA_W-1:0] mux_data;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    mux_data = '0;
    for (int i = 0; i < NUM_FN; i++)
      mux_data = mux_data | (fn_rdata[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}});
  end

  always_comb begin
    case (s1_kind)
      KIND_FWD_RD:    data_d = mux_data;
      KIND_ABSENT_RD: data_d = sized_ones(s1_size);
      default:        data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) rsp_rdata <= data_d;
    end
  end

  AST_SEL_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |=> rsp_valid); // R3

endmodule

// File: rtl/cfgr_err.sv
module cfgr_err
  import cfgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] evt,
  output logic [ERR_W-1:0] err_q
);

  logic [ERR_W-1:0] err_d;
  logic             err_en;

  always_comb begin
    err_en = |evt;
    err_d  = err_q | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q) |=> ((err_q & $past(err_q)) == $past(err_q))); // R8

  AST_DUP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    evt[ERR_DUP] |=> err_q[ERR_DUP]); // R7

endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfgr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK = '1,
  parameter int                NUM_FN   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [SIZE_W-1:0]        req_size,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [NUM_FN-1:0]        claim_valid,
  input  logic [NUM_FN*SLOT_W-1:0] claim_slot,
  output logic [NUM_FN-1:0]        fn_sel,
  output logic                     fn_write,
  output logic [OFF_W-1:0]         fn_offset,
  output logic [SIZE_W-1:0]        fn_size,
  output logic [DATA_W-1:0]        fn_wdata,
  input  logic [NUM_FN*DATA_W-1:0] fn_rdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ERR_W-1:0]         err_status
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [SLOT_W-1:0] dec_slot;
  logic [OFF_W-1:0]  dec_off;
  logic              dec_legal;
  logic [NUM_FN-1:0] hit_vec;
  logic              hit;
  logic              dup;

  cfgr_decode #(.ADDR_W(ADDR_W), .WIN_MASK(WIN_MASK)) u_decode (
    .addr   (req_addr),
    .size   (req_size),
    .slot   (dec_slot),
    .offset (dec_off),
    .legal  (dec_legal)
  );

  cfgr_match #(.NUM_FN(NUM_FN)) u_match (
    .claim_valid (claim_valid),
    .claim_slot  (claim_slot),
    .tgt_slot    (dec_slot),
    .hit_vec     (hit_vec),
    .hit         (hit),
    .dup         (dup)
  );

  // stage 1: select and forwarded fields
  logic [NUM_FN-1:0] s1_sel_d, s1_sel_q;
  rsp_kind_e         s1_kind_d, s1_kind_q;
  logic              s1_valid_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic [SIZE_W-1:0] s1_size_q;
  logic              s1_write_q;
  logic [DATA_W-1:0] s1_wdata_q;
  logic [ERR_W-1:0]  err_evt;

  always_comb begin
    s1_sel_d  = '0;
    s1_kind_d = KIND_NODATA;
    if (req_valid && dec_legal) begin
      if (hit) begin
        s1_sel_d  = hit_vec;
        s1_kind_d = req_write ? KIND_FWD_WR : KIND_FWD_RD;
      end else begin
        s1_kind_d = req_write ? KIND_NODATA : KIND_ABSENT_RD;
      end
    end
  end

  always_comb begin
    err_evt             = '0;
    err_evt[ERR_SIZE]   = req_valid && !dec_legal;
    err_evt[ERR_ABS_WR] = req_valid && dec_legal && req_write && !hit;
    err_evt[ERR_DUP]    = dup;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      s1_valid_q <= 1'b0;
      s1_sel_q   <= '0;
      s1_kind_q  <= KIND_NODATA;
      s1_off_q   <= '0;
      s1_size_q  <= '0;
      s1_write_q <= 1'b0;
      s1_wdata_q <= '0;
    end else begin
      s1_valid_q <= req_valid;
      s1_sel_q   <= s1_sel_d;
      if (req_valid) begin
        s1_kind_q  <= s1_kind_d;
        s1_off_q   <= dec_off;
        s1_size_q  <= req_size;
        s1_write_q <= req_write;
        s1_wdata_q <= req_wdata;
      end
    end
  end

  assign fn_sel    = s1_sel_q;
  assign fn_write  = s1_write_q;
  assign fn_offset = s1_off_q;
  assign fn_size   = s1_size_q;
  assign fn_wdata  = s1_wdata_q;

  cfgr_resp #(.NUM_FN(NUM_FN)) u_resp (
    .clk       (clk),
    .rst_n     (rst_s),
    .s1_valid  (s1_valid_q),
    .s1_kind   (s1_kind_q),
    .s1_size   (s1_size_q),
    .sel       (s1_sel_q),
    .fn_rdata  (fn_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  cfgr_err u_err (
    .clk   (clk),
    .rst_n (rst_s),
    .evt   (err_evt),
    .err_q (err_status)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(fn_sel)); // R2

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_s)
    (|fn_sel) |-> $past(req_valid)); // R2

  AST_BADSIZE_NOSEL: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !dec_legal) |=> (fn_sel == '0)); // R6

  AST_ABSENT_NOSEL: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && dec_legal && !hit) |=> (fn_sel == '0)); // R4

endmodule

// File: tb/test_cfg_router.sv
module test_cfg_router;
  import cfgr_pkg::*;

  localparam int NF = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [15:0]       req_addr;
  logic [2:0]        req_size;
  logic [31:0]       req_wdata;
  logic [NF-1:0]     claim_valid;
  logic [NF*8-1:0]   claim_slot;
  logic [NF-1:0]     fn_sel;
  logic              fn_write;
  logic [7:0]        fn_offset;
  logic [2:0]        fn_size;
  logic [31:0]       fn_wdata;
  logic [NF*32-1:0]  fn_rdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [2:0]        err_status;

  always #2 clk = ~clk; // 250 MHz

  cfg_router #(.ADDR_W(16), .NUM_FN(NF)) i_cfg_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .claim_valid(claim_valid), .claim_slot(claim_slot), .fn_sel(fn_sel),
    .fn_write(fn_write), .fn_offset(fn_offset), .fn_size(fn_size),
    .fn_wdata(fn_wdata), .fn_rdata(fn_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_status(err_status)
  );

  // agent model: each returns a tagged word that echoes the offset
  function automatic logic [31:0] agent_word(input int idx, input logic [7:0] off);
    return {idx[7:0], 8'hC3, 8'h5A, off};
  endfunction

  for (genvar g = 0; g < NF; g++) begin : g_agent
    assign fn_rdata[g*32 +: 32] = agent_word(g, fn_offset);
  end

  typedef struct {
    int          sel;
    logic        wr;
    logic [7:0]  off;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] rdata;
    string       tag;
  } item_t;

  item_t sel_q[$];
  item_t rsp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  logic  sel_due;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) sel_due <= req_valid && rst_n;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (sel_due) begin
      if (sel_q.size() == 0) chk(1'b0, "R9 unexpected select slot", 32'(fn_sel), 0);
      else begin
        item_t e;
        logic [NF-1:0] exp_sel;
        e = sel_q.pop_front();
        exp_sel = (e.sel < 0) ? '0 : NF'(1) << e.sel;
        chk(fn_sel == exp_sel, {e.tag, " select"}, 32'(fn_sel), 32'(exp_sel));
        if (e.sel >= 0)
          chk(fn_offset == e.off && fn_size == e.size && fn_write == e.wr &&
              (!e.wr || fn_wdata == e.wdata), {e.tag, " R2 fields"},
              {fn_offset, 5'd0, fn_size, 16'(fn_wdata)},
              {e.off, 5'd0, e.size, 16'(e.wdata)});
      end
    end else if (fn_sel != '0) begin
      chk(1'b0, "R2 select without request", 32'(fn_sel), 0);
    end
    if (rsp_valid) begin
      if (rsp_q.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 0);
      else begin
        item_t e;
        e = rsp_q.pop_front();
        chk(rsp_rdata == e.rdata, {e.tag, " response"}, rsp_rdata, e.rdata);
      end
    end
  end

  task automatic do_req(input logic wr, input logic [4:0] dev, input logic [2:0] fn,
                        input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input int exp_sel,
                        input logic [31:0] exp_rd, input string tag);
    item_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {dev, fn, off};
    req_size  = sz;
    req_wdata = wd;
    e = '{exp_sel, wr, off, sz, wd, exp_rd, tag};
    sel_q.push_back(e);
    rsp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 3'd4; req_wdata = '0;
    claim_valid = 4'b1111;
    claim_slot  = {8'h00, 8'hFF, 8'h19, 8'h18}; // agents 3..0
    repeat (4) @(negedge clk);
    chk(fn_sel == '0, "R8 reset select", 32'(fn_sel), 0);
    chk(!rsp_valid, "R8 reset response", 32'(rsp_valid), 0);
    chk(err_status == '0, "R8 reset errors", 32'(err_status), 0);
    rst_n = 1'b1;
    idle(4);

    // R1 R2 R3: forwarded reads and a write
    do_req(1'b0, 5'd3,  3'd0, 8'h10, 3'd4, 0, 0, agent_word(0, 8'h10), "R1 R3 read dev3 fn0");
    idle(3);
    do_req(1'b0, 5'd31, 3'd7, 8'hFC, 3'd2, 0, 2, agent_word(2, 8'hFC), "R1 R3 read dev31 fn7");
    idle(3);
    do_req(1'b1, 5'd3,  3'd1, 8'h04, 3'd4, 32'hDEAD_BEEF, 1, 32'h0, "R2 R3 write dev3 fn1");
    idle(3);
    do_req(1'b0, 5'd0,  3'd0, 8'h3C, 3'd1, 0, 3, agent_word(3, 8'h3C), "R1 read dev0 fn0");
    idle(3);

    // R4: unclaimed slots, each size
    do_req(1'b0, 5'd5, 3'd0, 8'h00, 3'd1, 0, -1, 32'h0000_00FF, "R4 absent size1");
    idle(3);
    do_req(1'b0, 5'd3, 3'd2, 8'h02, 3'd2, 0, -1, 32'h0000_FFFF, "R4 absent size2");
    idle(3);
    do_req(1'b0, 5'd30, 3'd7, 8'h08, 3'd4, 0, -1, 32'hFFFF_FFFF, "R4 absent size4");
    idle(3);
    chk(err_status == 3'b000, "R4 no error on absent read", 32'(err_status), 0);

    // R9: back-to-back mix
    do_req(1'b0, 5'd3,  3'd1, 8'h20, 3'd4, 0, 1, agent_word(1, 8'h20), "R9 b2b a");
    do_req(1'b0, 5'd9,  3'd3, 8'h01, 3'd2, 0, -1, 32'h0000_FFFF, "R9 b2b b");
    do_req(1'b1, 5'd31, 3'd7, 8'h40, 3'd2, 32'h0000_1234, 2, 32'h0, "R9 b2b c");
    do_req(1'b0, 5'd3,  3'd0, 8'h7F, 3'd1, 0, 0, agent_word(0, 8'h7F), "R9 b2b d");
    idle(4);

    // R5: write to unclaimed slot
    do_req(1'b1, 5'd7, 3'd2, 8'h10, 3'd4, 32'hCAFE_0001, -1, 32'h0, "R5 absent write");
    idle(3);
    chk(err_status == 3'b010, "R5 error bit1", 32'(err_status), 32'b010);

    // R6: illegal sizes on a claimed slot
    do_req(1'b0, 5'd3, 3'd0, 8'h10, 3'd3, 0, -1, 32'h0, "R6 size3 read");
    do_req(1'b1, 5'd3, 3'd1, 8'h10, 3'd0, 32'h55, -1, 32'h0, "R6 size0 write");
    idle(3);
    chk(err_status == 3'b011, "R6 error bit0 only", 32'(err_status), 32'b011);

    // R7: duplicate claim, lowest index wins
    @(negedge clk);
    claim_slot[3*8 +: 8] = 8'h19;
    idle(2);
    chk(err_status == 3'b111, "R7 duplicate flagged", 32'(err_status), 32'b111);
    do_req(1'b0, 5'd3, 3'd1, 8'h0C, 3'd4, 0, 1, agent_word(1, 8'h0C), "R7 lowest claimant");
    idle(3);

    // R8: sticky after cause removed, then cleared by reset
    claim_slot[3*8 +: 8] = 8'h00;
    idle(3);
    chk(err_status == 3'b111, "R8 sticky", 32'(err_status), 32'b111);
    rst_n = 1'b0;
    idle(2);
    chk(err_status == 3'b000, "R8 cleared by reset", 32'(err_status), 0);
    rst_n = 1'b1;
    idle(4);
    do_req(1'b0, 5'd0, 3'd0, 8'h44, 3'd4, 0, 3, agent_word(3, 8'h44), "R8 after reset read");
    idle(4);

    chk(sel_q.size() == 0 && rsp_q.size() == 0, "R9 all responses seen",
        32'(rsp_q.size()), 0);
    summary();
    $finish;
  end

endmodule